// File: doc/BRIEF.md
# PCM Serial Port with Cipher Word Alignment

This block is the serial side of one channel of a voice-stream cipher. A bit clock and a frame sync pulse come in from the PCM highway. After each sync pulse the block receives an 8-bit sample on the falling bit-clock edges and sends an 8-bit result on the rising edges. Outside that eight-bit window the input is ignored and the output enable is low, which models a 3-state pin. A sample is handed to the cipher as a parallel byte. A byte to send comes back from the cipher through a valid/ready input.

The width of the sync pulse carries a second message. A pulse one bit clock wide marks an ordinary frame. A pulse two or more bit clocks wide marks the start of a 64-bit cipher word, which is made of eight consecutive samples. A free-running modulo-8 sample counter keeps the word alignment between wide pulses. So a wide pulse is needed only once, or at any multiple of eight frames. Each received byte carries its index within the word. It also carries a word-start flag, and that flag is never raised before the first wide pulse after reset.

All inputs are sampled in the system clock domain. The bit clock is expected to run at least four times slower than the system clock. The receive side has no back-pressure, because a serial stream cannot be stalled. The transmit side applies back-pressure through `tx_ready`: it holds one byte, and it takes the next byte only after the frame start has consumed the one it holds.

Top module: `pcm_word_port`

## Requirements
- R1: After reset `ser_oe`, `rx_valid` and `misalign` are 0 and `tx_ready` is 1.
- R2: A frame starts on the first rising bit-clock edge that samples `fsync` low after one or more edges that sampled it high. The eight following falling edges capture `ser_in` MSB first. Input on any other edge has no effect on `rx_data`.
- R3: Starting at the frame-start rising edge, eight consecutive rising edges drive the transmit byte onto `ser_out`, MSB first. `ser_oe` is high for exactly those eight bit periods and goes low at the ninth rising edge.
- R4: A sync pulse that spans one rising edge is ordinary. A pulse that spans two or more rising edges is a word boundary: the frame it starts gets `rx_idx` 0 and `rx_word_start` 1.
- R5: An ordinary frame gets the previous index plus one, modulo 8. The counter wraps to 0 by itself, and a frame with index 0 after the wrap has `rx_word_start` 1.
- R6: Until a wide pulse has been seen after reset, `rx_word_start` stays 0, even for a frame with index 0.
- R7: `misalign` pulses for one system clock when a wide pulse starts a frame whose free-running index would not have been 0. Otherwise it stays 0.
- R8: While `ser_idle` is 1, `ser_oe` is 0. Reception and index counting go on unchanged.
- R9: `tx_ready` is 1 when the one-byte buffer is empty. A byte is taken when `tx_valid` and `tx_ready` are both 1, and then `tx_ready` drops. Each frame start empties the buffer into the shifter. If the buffer is empty at a frame start, that frame sends 8'hFF.
- R10: `rx_valid` is a one-cycle pulse, once per frame, at the eighth capturing edge. `rx_data`, `rx_idx` and `rx_word_start` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk | input | 1 | Serial bit clock, sampled by clk |
| fsync | input | 1 | Frame sync; its width in bit clocks marks a word boundary |
| ser_in | input | 1 | Serial receive data |
| ser_idle | input | 1 | Forces the serial output off |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Output enable of the serial pin |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| rx_idx | output | 3 | Sample index within the 64-bit word |
| rx_word_start | output | 1 | Received byte is the first of a word |
| misalign | output | 1 | Wide pulse arrived off an 8-frame boundary |

## Verification
Two situations are hard to reach from the ports. The first is a wide pulse that arrives when the free-running index is not at a boundary. The bench gets there by walking a frame table in which the counter first wraps on its own. Wide pulses of width two and three then arrive at indices 1 and 0, so `misalign` must fire while the index is still forced to 0. The second is a frame start with an empty transmit buffer. A directed frame skips the push to reach it. Another directed frame re-applies reset so that an index-0 frame arrives before any wide pulse.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  parameter int unsigned SAMPLE_BITS = 8;
  parameter int unsigned WORD_FRAMES = 8;
  parameter int unsigned SYNC_CNT_W  = 2;
  localparam int unsigned IDX_W = $clog2(WORD_FRAMES);
endpackage

// File: rtl/pcm_fsync_tracker.sv
module pcm_fsync_tracker #(
  parameter int unsigned FRAMES = pcm_port_pkg::WORD_FRAMES,
  parameter int unsigned SYNC_W = pcm_port_pkg::SYNC_CNT_W,
  localparam int unsigned IW    = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          fsync,
  output logic          bit_rise,
  output logic          bit_fall,
  output logic          frame_start,
  output logic [IW-1:0] frame_idx,
  output logic          word_start,
  output logic          misalign
);
  localparam logic [IW-1:0]     LAST_IDX = IW'(FRAMES - 1);
  localparam logic [SYNC_W-1:0] SYNC_MAX = '1;

  logic              bclk_q;
  logic [SYNC_W-1:0] sync_len;
  logic              synced;
  logic              wide;
  logic [IW-1:0]     idx_next;

  assign bit_rise    = bclk & ~bclk_q;
  assign bit_fall    = ~bclk & bclk_q;
  assign frame_start = bit_rise & ~fsync & (sync_len != '0);
  assign wide        = sync_len >= SYNC_W'(2);
  assign idx_next    = (frame_idx == LAST_IDX) ? '0 : frame_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      sync_len   <= '0;
      frame_idx  <= LAST_IDX;
      synced     <= 1'b0;
      word_start <= 1'b0;
      misalign   <= 1'b0;
    end else begin
      bclk_q   <= bclk;
      misalign <= 1'b0;
      if (bit_rise) begin
        if (fsync) sync_len <= (sync_len == SYNC_MAX) ? sync_len : sync_len + 1'b1;
        else       sync_len <= '0;
      end
      if (frame_start) begin
        if (wide) begin
          frame_idx  <= '0;
          synced     <= 1'b1;
          word_start <= 1'b1;
          misalign   <= (idx_next != '0);
        end else begin
          frame_idx  <= idx_next;
          word_start <= synced & (idx_next == '0);
        end
      end
    end
  end

  AST_WIDE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && wide |=> frame_idx == '0 && word_start); // R4
  AST_IDX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !wide && frame_idx != LAST_IDX |=> frame_idx == $past(frame_idx) + 1'b1); // R5
  AST_START_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> synced); // R6
  AST_MISALIGN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> frame_idx == '0 && word_start); // R7
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
  parameter int unsigned W = pcm_port_pkg::SAMPLE_BITS,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic         bit_fall,
  input  logic         ser_in,
  output logic         rx_valid,
  output logic [W-1:0] rx_data
);
  logic          open_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg;
  logic [W-1:0]  shnext;

  assign shnext = {shreg[W-2:0], ser_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (frame_start) begin
        open_q <= 1'b1;
        cnt    <= '0;
      end else if (bit_fall && open_q) begin
        shreg <= shnext;
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          open_q   <= 1'b0;
          rx_valid <= 1'b1;
          rx_data  <= shnext;
        end
      end
    end
  end

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R10
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int unsigned W = pcm_port_pkg::SAMPLE_BITS,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic         bit_rise,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  output logic         ser_bit,
  output logic         active
);
  logic          full;
  logic [W-1:0]  hold;
  logic [W-1:0]  shreg;
  logic [CW-1:0] sent;
  logic          take;

  assign tx_ready = ~full;
  assign take     = tx_valid & ~full;
  assign ser_bit  = shreg[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      hold   <= '0;
      shreg  <= '1;
      sent   <= '0;
      active <= 1'b0;
    end else begin
      if (take) hold <= tx_data;
      if (frame_start) begin
        shreg  <= full ? hold : '1;
        full   <= take;
        active <= 1'b1;
        sent   <= CW'(1);
      end else begin
        if (take) full <= 1'b1;
        if (bit_rise && active) begin
          if (sent == CW'(W)) begin
            active <= 1'b0;
          end else begin
            shreg <= {shreg[W-2:0], 1'b1};
            sent  <= sent + 1'b1;
          end
        end
      end
    end
  end

  AST_TX_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !frame_start |=> !tx_ready); // R9
  AST_TX_STARTS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> active); // R3
endmodule

// File: rtl/pcm_word_port.sv
module pcm_word_port #(
  parameter int unsigned SAMPLE_BITS = pcm_port_pkg::SAMPLE_BITS,
  parameter int unsigned WORD_FRAMES = pcm_port_pkg::WORD_FRAMES,
  parameter int unsigned SYNC_CNT_W  = pcm_port_pkg::SYNC_CNT_W,
  localparam int unsigned IW         = $clog2(WORD_FRAMES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bclk,
  input  logic                   fsync,
  input  logic                   ser_in,
  input  logic                   ser_idle,
  output logic                   ser_out,
  output logic                   ser_oe,
  input  logic                   tx_valid,
  output logic                   tx_ready,
  input  logic [SAMPLE_BITS-1:0] tx_data,
  output logic                   rx_valid,
  output logic [SAMPLE_BITS-1:0] rx_data,
  output logic [IW-1:0]          rx_idx,
  output logic                   rx_word_start,
  output logic                   misalign
);
  logic bit_rise;
  logic bit_fall;
  logic frame_start;
  logic tx_active;

  pcm_fsync_tracker #(.FRAMES(WORD_FRAMES), .SYNC_W(SYNC_CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .bit_rise(bit_rise), .bit_fall(bit_fall), .frame_start(frame_start),
    .frame_idx(rx_idx), .word_start(rx_word_start), .misalign(misalign)
  );

  pcm_rx_shift #(.W(SAMPLE_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_fall(bit_fall),
    .ser_in(ser_in), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  pcm_tx_shift #(.W(SAMPLE_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_rise(bit_rise),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .ser_bit(ser_out), .active(tx_active)
  );

  assign ser_oe = tx_active & ~ser_idle;

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ser_idle |-> !ser_oe); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> !ser_oe && !rx_valid && !misalign && tx_ready); // R1
endmodule

// File: tb/pcm_word_port_bench.sv
`timescale 1ns/1ps
module pcm_word_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, ser_in = 1'b0, ser_idle = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic ser_out, ser_oe, tx_ready, rx_valid, rx_word_start, misalign;
  logic [7:0] rx_data;
  logic [2:0] rx_idx;

  int checks = 0;
  int errors = 0;
  int rx_seen = 0, mis_seen = 0;
  logic [7:0] last_rx;
  logic [2:0] last_idx;
  logic last_ws;

  always #2.5 clk = ~clk;

  pcm_word_port u_pcm_word_port (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .ser_in(ser_in),
    .ser_idle(ser_idle), .ser_out(ser_out), .ser_oe(ser_oe),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_idx(rx_idx),
    .rx_word_start(rx_word_start), .misalign(misalign)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_seen++;
      last_rx  = rx_data;
      last_idx = rx_idx;
      last_ws  = rx_word_start;
    end
    if (misalign) mis_seen++;
  end

  // {width[22:21], rx[20:13], tx[12:5], idx[4:2], word_start[1], misalign[0]}
  localparam logic [22:0] VEC [0:19] = '{
    {2'd2, 8'hA5, 8'h3C, 3'd0, 1'b1, 1'b0},
    {2'd1, 8'h01, 8'h80, 3'd1, 1'b0, 1'b0},
    {2'd1, 8'hFE, 8'h7F, 3'd2, 1'b0, 1'b0},
    {2'd1, 8'h00, 8'hFF, 3'd3, 1'b0, 1'b0},
    {2'd1, 8'h55, 8'hAA, 3'd4, 1'b0, 1'b0},
    {2'd1, 8'hC3, 8'h96, 3'd5, 1'b0, 1'b0},
    {2'd1, 8'h18, 8'hE7, 3'd6, 1'b0, 1'b0},
    {2'd1, 8'h81, 8'h42, 3'd7, 1'b0, 1'b0},
    {2'd1, 8'hF0, 8'h0F, 3'd0, 1'b1, 1'b0},
    {2'd1, 8'h12, 8'h34, 3'd1, 1'b0, 1'b0},
    {2'd2, 8'h9A, 8'hBC, 3'd0, 1'b1, 1'b1},
    {2'd3, 8'hDE, 8'hAD, 3'd0, 1'b1, 1'b1},
    {2'd1, 8'h77, 8'hEE, 3'd1, 1'b0, 1'b0},
    {2'd1, 8'h6B, 8'h00, 3'd2, 1'b0, 1'b0},
    {2'd1, 8'h3E, 8'h11, 3'd3, 1'b0, 1'b0},
    {2'd1, 8'hC0, 8'h22, 3'd4, 1'b0, 1'b0},
    {2'd1, 8'h0F, 8'h33, 3'd5, 1'b0, 1'b0},
    {2'd1, 8'hB4, 8'h44, 3'd6, 1'b0, 1'b0},
    {2'd1, 8'h29, 8'h55, 3'd7, 1'b0, 1'b0},
    {2'd2, 8'hE1, 8'h66, 3'd0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_bit(input logic fs, input logic d, output logic oe_s, output logic so_s);
    bclk = 1'b1; fsync = fs; ser_in = d;
    repeat (4) @(negedge clk);
    oe_s = ser_oe; so_s = ser_out;
    bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input int w, input logic [7:0] rx, input logic [7:0] tx,
                       input bit push, output logic [7:0] got, output int oe_cnt,
                       output logic gap_oe, output int nrx, output int nmis);
    logic oe_s, so_s;
    int rx0, mis0;
    if (push) begin
      chk("R9 ready before push", int'(tx_ready), 1);
      tx_valid = 1'b1; tx_data = tx;
      @(negedge clk);
      tx_valid = 1'b0;
      chk("R9 ready drops after take", int'(tx_ready), 0);
    end
    rx0 = rx_seen; mis0 = mis_seen; oe_cnt = 0; got = '0;
    for (int i = 0; i < w; i++) run_bit(1'b1, 1'b1, oe_s, so_s);   // R2 input ignored here
    for (int i = 0; i < 8; i++) begin
      run_bit(1'b0, rx[7-i], oe_s, so_s);
      if (oe_s === 1'b1) oe_cnt++;
      got[7-i] = so_s;
    end
    run_bit(1'b0, ~rx[0], gap_oe, so_s);                               // R2 gap bit ignored
    nrx = rx_seen - rx0; nmis = mis_seen - mis0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", wd);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] got;
    int oe_cnt, nrx, nmis;
    logic gap_oe;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", int'(ser_oe), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 misalign", int'(misalign), 0);
    chk("R1 tx_ready", int'(tx_ready), 1);
    for (int i = 0; i < 2; i++) run_bit(1'b0, 1'b1, gap_oe, got[0]);

    for (int v = 0; v < 20; v++) begin
      frame(int'(VEC[v][22:21]), VEC[v][20:13], VEC[v][12:5], 1'b1, got, oe_cnt, gap_oe, nrx, nmis);
      chk("R10 one rx strobe", nrx, 1);
      chk("R2 rx byte", int'(last_rx), int'(VEC[v][20:13]));
      chk("R4/R5 index", int'(last_idx), int'(VEC[v][4:2]));
      chk("R5/R6 word start", int'(last_ws), int'(VEC[v][1]));
      chk("R7 misalign", nmis, int'(VEC[v][0]));
      chk("R3 tx byte", int'(got), int'(VEC[v][12:5]));
      chk("R3 oe window", oe_cnt, 8);
      chk("R3 oe off after", int'(gap_oe), 0);
    end

    // R8 idle: output silent, reception continues
    ser_idle = 1'b1;
    frame(1, 8'h5A, 8'hC6, 1'b1, got, oe_cnt, gap_oe, nrx, nmis);
    ser_idle = 1'b0;
    chk("R8 idle oe", oe_cnt, 0);
    chk("R8 idle rx byte", int'(last_rx), 32'h5A);
    chk("R8 idle index", int'(last_idx), 1);

    // R9 underrun: no byte offered
    frame(1, 8'h3D, 8'h00, 1'b0, got, oe_cnt, gap_oe, nrx, nmis);
    chk("R9 underrun byte", int'(got), 32'hFF);
    chk("R9 underrun index", int'(last_idx), 2);

    // R6 reset again: index-0 frame before any wide pulse
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 re-reset ready", int'(tx_ready), 1);
    frame(1, 8'h2C, 8'h4B, 1'b1, got, oe_cnt, gap_oe, nrx, nmis);
    chk("R6 index after reset", int'(last_idx), 0);
    chk("R6 no word start yet", int'(last_ws), 0);
    chk("R7 narrow no misalign", nmis, 0);
    chk("R3 tx after reset", int'(got), 32'h4B);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule